// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block runs one read or write access to an asynchronous static memory on a multiplexed local bus. A requester presents a direction, per-lane byte enables and the option word of the selected bank. The option word holds a wait count, a relaxed-timing flag, an acknowledge-source flag and an early-negation flag. The block then drives the active-low chip select, output enable and per-lane write enables, and it pulses `done` when the access is over.

The block runs on a fast clock that is 2, 4 or 8 times the bus clock. The requester picks the ratio with `clk_ratio`. The strobe stays asserted for one bus cycle plus the wait states. The wait counter normally ends the access. When the acknowledge-source flag selects the external acknowledge, that input can end the access early. It only does so if it arrives while at least two wait cycles are still to run.

Address latching, bank decode, the data path and bus arbitration are handled outside the block.

Top module: `sram_wait_ctrl`

## Requirements
- R1: After reset and while idle, `cs_n`, `oe_n` and every `we_n` bit are 1 and `done` is 0.
- R2: A request (`req_valid`=1) is taken only while idle. A request made during an access changes neither that access nor what follows it, and no second access starts.
- R3: `cs_n` is 0 for one bus cycle of address phase, followed by the whole strobe phase. It is 1 while `done` is high. A strobe is never low while `cs_n` is 1.
- R4: A read (`req_write`=0) drives only `oe_n` low. A write drives only `we_n[i]` for each lane i whose `req_be[i]`=1. Lanes with `req_be[i]`=0 stay high.
- R5: With `opt_relax`=0 and the counter ending the access, the strobe lasts (1 + `opt_wait`) bus cycles. `opt_wait` is 4 bits, 0 to 15.
- R6: With `opt_relax`=1 the wait count is doubled, so the strobe lasts (1 + 2·`opt_wait`) bus cycles. That is at most 30 wait states.
- R7: `clk_ratio` sets the fast ticks per bus cycle: 0 gives 2, 1 gives 4, and 2 or 3 give 8.
- R8: With `opt_early`=1 at a ratio of 4 or 8, a counter-ended strobe is released a quarter bus cycle early: 1 tick at ratio 4 and 2 ticks at ratio 8. At ratio 2 the flag has no effect.
- R9: With `opt_ack_ext`=1, `ext_ack` is sampled on the last tick of each strobe bus cycle. If it is high while at least two wait cycles remain, the strobe ends after that bus cycle, at full width with no early cut.
- R10: `ext_ack` is ignored when `opt_ack_ext`=0, and also when fewer than two wait cycles remain. In both cases the counter ends the access.
- R11: After the strobe phase, `done` is high for exactly one bus cycle with all strobes released. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (2/4/8 × bus clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ratio | input | 2 | Fast ticks per bus cycle select |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | LANES | Byte lane enables |
| opt_wait | input | WAIT_W | Base wait-state count |
| opt_relax | input | 1 | Double the wait count |
| opt_ack_ext | input | 1 | Allow external acknowledge |
| opt_early | input | 1 | Quarter-cycle early strobe release |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | LANES | Per-lane write enables, active low |
| done | output | 1 | Access finished, one bus cycle pulse |

## Verification
The assertions check, on every cycle, the ordering rules between the outputs. Output enable and write enables are never low together, and no strobe is low without chip select. Chip select is already low when a strobe falls. `done` only rises after chip select was low, never overlaps a strobe, and never lasts beyond eight ticks. The widths themselves can only be shown by the bench scenarios, which count strobe, chip-select and done ticks for each case. Those cases cover each ratio, the wait extremes, doubling, the early cut and the external-acknowledge race with a late or disabled acknowledge.

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl #(
  parameter int LANES  = 2,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        clk_ratio,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LANES-1:0]  req_be,
  input  logic [WAIT_W-1:0] opt_wait,
  input  logic              opt_relax,
  input  logic              opt_ack_ext,
  input  logic              opt_early,
  input  logic              ext_ack,
  output logic              cs_n,
  output logic              oe_n,
  output logic [LANES-1:0]  we_n,
  output logic              done
);
  localparam int REM_W = WAIT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB, S_DONE} state_t;

  state_t             state;
  logic [2:0]         tick, last_tick;
  logic [REM_W-1:0]   rem;
  logic               wr, ack_ext, early;
  logic [LANES-1:0]   be;

  logic       bus_end, cut, strobe_on;
  logic [2:0] cut_at;

  assign bus_end   = (tick == last_tick);
  assign cut_at    = last_tick - (last_tick >> 2);
  assign cut       = early && (rem == '0) && (tick >= cut_at);
  assign strobe_on = (state == S_STRB) && !cut;

  assign cs_n = !((state == S_ADDR) || (state == S_STRB));
  assign oe_n = !(strobe_on && !wr);
  assign we_n = ~({LANES{strobe_on && wr}} & be);
  assign done = (state == S_DONE);

  function automatic logic [2:0] ratio_last(input logic [1:0] r);
    case (r)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tick      <= '0;
      last_tick <= 3'd1;
      rem       <= '0;
      wr        <= 1'b0;
      ack_ext   <= 1'b0;
      early     <= 1'b0;
      be        <= '0;
    end else begin
      if (state == S_IDLE) begin
        tick <= '0;
        if (req_valid) begin
          state     <= S_ADDR;
          last_tick <= ratio_last(clk_ratio);
          rem       <= opt_relax ? {opt_wait, 1'b0} : {1'b0, opt_wait};
          wr        <= req_write;
          be        <= req_be;
          ack_ext   <= opt_ack_ext;
          early     <= opt_early && (clk_ratio != 2'd0);
        end
      end else begin
        tick <= bus_end ? 3'd0 : tick + 3'd1;
        if (bus_end) begin
          case (state)
            S_ADDR: state <= S_STRB;
            S_STRB: begin
              if (rem == '0)
                state <= S_DONE;
              else if (ack_ext && ext_ack && rem >= REM_W'(2)) begin
                state <= S_DONE;
                rem   <= '1;
              end else
                rem <= rem - REM_W'(1);
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sram_wait_ctrl_chk.sv
module sram_wait_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             oe_n,
  input logic [LANES-1:0] we_n,
  input logic             done
);
  logic [3:0] dcnt;
  logic       any_we;
  assign any_we = !(&we_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= done ? dcnt + 4'd1 : 4'd0;

  AST_STROBE_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && any_we)); // R4
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) (!oe_n || any_we) |-> !cs_n); // R3
  AST_CS_BEFORE_OE:    assert property (@(posedge clk) disable iff (!rst_n) $fell(oe_n) |-> $past(!cs_n)); // R3
  AST_DONE_RELEASED:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && oe_n && !any_we)); // R11
  AST_DONE_AFTER_CS:   assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(!cs_n)); // R11
  AST_DONE_WIDTH:      assert property (@(posedge clk) disable iff (!rst_n) done |-> (dcnt < 4'd8)); // R7
endmodule

bind sram_wait_ctrl sram_wait_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .done(done)
);

// File: tb/tb_sram_wait_ctrl.sv
`timescale 1ns/1ps
module tb_sram_wait_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] clk_ratio = '0;
  logic       req_valid = 0, req_write = 0, opt_relax = 0, opt_ack_ext = 0, opt_early = 0, ext_ack = 0;
  logic [1:0] req_be = '0;
  logic [3:0] opt_wait = '0;
  logic       cs_n, oe_n, done;
  logic [1:0] we_n;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sram_wait_ctrl dut (.*);

  typedef struct packed {
    logic [1:0] ratio; logic [3:0] w; logic relax; logic early; logic wr;
    logic [1:0] be; logic acks; logic ext; int es; int ecs;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{2'd1, 4'd0,  1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0,   4,   8}, // R5 R7
    '{2'd1, 4'd0,  1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0,   3,   8}, // R8
    '{2'd1, 4'd1,  1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0,   8,  12}, // R4 R5
    '{2'd1, 4'd1,  1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0,  12,  16}, // R6
    '{2'd1, 4'd15, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0,  64,  68}, // R5
    '{2'd1, 4'd15, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 124, 128}, // R6 R4
    '{2'd2, 4'd1,  1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0,  22,  32}, // R8 R4
    '{2'd0, 4'd1,  1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0,   4,   6}, // R8 ratio 2
    '{2'd3, 4'd0,  1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0,   6,  16}, // R7 R8
    '{2'd0, 4'd15, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0,  62,  64}, // R6 R7
    '{2'd1, 4'd2,  1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1,   4,   8}, // R9
    '{2'd1, 4'd1,  1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1,   8,  12}, // R10 late
    '{2'd1, 4'd2,  1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1,  12,  16}, // R10 disabled
    '{2'd1, 4'd5,  1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1,   4,   8}, // R9 no cut
    '{2'd2, 4'd3,  1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1,   8,  16}  // R9 ratio 8
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ticks_per(input logic [1:0] r);
    return (r == 2'd0) ? 2 : (r == 2'd1) ? 4 : 8;
  endfunction

  task automatic run(input vec_t v, input bit poke);
    int noe = 0, ncs = 0, nd = 0, k = 0;
    int nwe [2] = '{0, 0};
    bit seen = 0;
    @(negedge clk);
    clk_ratio = v.ratio; opt_wait = v.w; opt_relax = v.relax; opt_early = v.early;
    req_write = v.wr; req_be = v.be; opt_ack_ext = v.acks; ext_ack = v.ext; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (k < 3000) begin
      if (poke && k == 3) begin
        req_valid = 1; req_write = 1; req_be = 2'b11; opt_wait = 4'd0; clk_ratio = 2'd0;
      end else req_valid = 0;
      if (!cs_n) ncs++;
      if (!oe_n) noe++;
      for (int i = 0; i < 2; i++) if (!we_n[i]) nwe[i]++;
      if (done) begin nd++; seen = 1; end
      else if (seen) break;
      k++;
      @(negedge clk);
    end
    ext_ack = 0;
    check("R3 cs width", ncs, v.ecs);
    check("R11 done width", nd, ticks_per(v.ratio));
    check("R4 oe width", noe, v.wr ? 0 : v.es);
    for (int i = 0; i < 2; i++)
      check("R4 we lane width", nwe[i], (v.wr && v.be[i]) ? v.es : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset cs_n", cs_n, 1);
    check("R1 reset oe_n", oe_n, 1);
    check("R1 reset we_n", we_n, 2'b11);
    check("R1 reset done", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle cs_n", cs_n, 1);

    foreach (VEC[i]) run(VEC[i], 0);

    // R2: request during an access is ignored
    run('{2'd1, 4'd2, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 12, 16}, 1);
    begin
      int busy = 0;
      repeat (10) begin
        if (!cs_n || !oe_n || we_n != 2'b11) busy++;
        @(negedge clk);
      end
      check("R2 no second access", busy, 0);
    end
    check("R11 idle after done", done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule